// File: doc/BRIEF.md
# Programmable Clock Divider and Gating Controller

This block runs on a root clock and derives timing for the rest of a subsystem. It does not produce new clocks. It produces single-cycle clock-enable pulses. A system enable repeats every 2^k root cycles, with k from 0 to 7. A peripheral enable repeats every 2^k root cycles, with k from 2 to 7. A secondary enable follows the system enable.

Three peripheral enables are gated versions of these pulses. The UART enable is taken from the system enable. The two I2C enables are taken from the peripheral enable. Each gated enable is qualified by a per-peripheral off bit held in a control register, and by a 2-bit power-mode input. The deep power modes shut every peripheral enable off, whatever its off bit says.

Software reaches two 16-bit control registers through a small register bus. The bus has a write strobe, a read strobe, an address and data.
- The ratio register is at address 0.
- The gating register is at address 1.

A ratio change is held back until the running period ends, so no enable period is ever cut short.

Top module: `clkdiv_gate_ctrl`

## Requirements
- R1: The ratio register is at address 0 and resets to 0x0200. Its fields are:
  - bits [2:0]: system code, read-write.
  - bits [10:8]: peripheral code, read-write.
  - bit 11: secondary flag, read-only, always 0.
  - every other bit reads 0.

  A read strobe loads rdata on the next root edge. Any address other than 0 or 1 reads 0.
- R2: The gating register is at address 1 and resets to 0x0040. Its fields are:
  - bit 3: I2C0 off.
  - bit 4: I2C1 off.
  - bit 5: UART off.
  - bit 6: always reads 1.
  - every other bit reads 0, and writes to those bits are ignored.

  An off bit of 1 means the clock is off.
- R3: sys_en is a single-cycle pulse with a period of 2^code root cycles, where code is the system code. Code 0 keeps sys_en high on every cycle.
- R4: per_en is a single-cycle pulse with a period of 2^code root cycles, for peripheral codes 2 to 7. After reset the period is 4.
- R5: A write of peripheral code 000 or 001 leaves the peripheral code unchanged. The other fields of the same write still take effect.
- R6: A new ratio takes effect only when the current period completes. The first interval after the change therefore still equals the old ratio.
- R7: The period of per_en does not depend on the system code.
- R8: In power modes 0 and 1, each gated enable is high in the cycle after its source pulse, provided its off bit is 0. The source pulse is sys_en for uart_en and per_en for i2c0_en and i2c1_en. Otherwise the gated enable is low.
- R9: In power modes 2 and 3, uart_en, i2c0_en and i2c1_en are low whatever the off bits hold.
- R10: With the secondary flag at 0, sec_en equals sys_en on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Root clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| pwr_mode | input | 2 | Power mode, 0 to 3 |
| sys_en | output | 1 | System clock enable |
| per_en | output | 1 | Peripheral clock enable |
| sec_en | output | 1 | Secondary clock enable |
| uart_en | output | 1 | Gated UART enable |
| i2c0_en | output | 1 | Gated I2C0 enable |
| i2c1_en | output | 1 | Gated I2C1 enable |

## Verification
- **Register reads:** read data is due one root edge after the read strobe. The bench samples it at the following falling edge.
- **Ratio changes:** a new ratio shows up only after the old period ends. The bench waits at least two full old periods before it compares the measured pulse interval. For the no-shortening case it measures exactly the first interval that follows the write.
- **Gated enables:** these lag their source pulse by one root edge. The bench compares them against a copy of the source delayed by one cycle over a 200-cycle window, and it also counts the pulses. It opens the window only after settling time for the mode or gate change has passed.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int DATA_W        = 16;
  localparam int ADR_RATIO     = 0;
  localparam int ADR_GATE      = 1;
  // ratio register field positions
  localparam int SYS_LSB       = 0;
  localparam int PER_LSB       = 8;
  localparam int SEC_BIT       = 11;
  // gating register field positions
  localparam int I2C0_BIT      = 3;
  localparam int I2C1_BIT      = 4;
  localparam int UART_BIT      = 5;
  localparam int KEEP1_BIT     = 6;
  // peripheral code limits
  localparam int PER_MIN_CODE  = 2;
  localparam int PER_RST_CODE  = 2;
  // gated outputs
  localparam int NPER          = 3;
  localparam int IDX_UART      = 0;
  localparam int IDX_I2C0      = 1;
  localparam int IDX_I2C1      = 2;
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CODE_W   = 3,
  parameter bit SEC_HALF = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CODE_W-1:0] sys_code,
  output logic [CODE_W-1:0] per_code,
  output logic [NPER-1:0]   gate_off
);
  logic              hit_ratio, hit_gate;
  logic [CODE_W-1:0] per_wr;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wbits;

  assign hit_ratio    = (addr == ADDR_W'(ADR_RATIO));
  assign hit_gate     = (addr == ADDR_W'(ADR_GATE));
  assign per_wr       = wdata[PER_LSB +: CODE_W];
  assign unused_wbits = ^wdata;

  always_comb begin
    rd_mux = '0;
    if (hit_ratio) begin
      rd_mux[SYS_LSB +: CODE_W] = sys_code;
      rd_mux[PER_LSB +: CODE_W] = per_code;
      rd_mux[SEC_BIT]           = SEC_HALF;
    end else if (hit_gate) begin
      rd_mux[KEEP1_BIT] = 1'b1;
      rd_mux[UART_BIT]  = gate_off[IDX_UART];
      rd_mux[I2C0_BIT]  = gate_off[IDX_I2C0];
      rd_mux[I2C1_BIT]  = gate_off[IDX_I2C1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_code <= '0;
      per_code <= CODE_W'(PER_RST_CODE);
      gate_off <= '0;
      rdata    <= '0;
    end else begin
      if (wr_en && hit_ratio) begin
        sys_code <= wdata[SYS_LSB +: CODE_W];
        if (per_wr >= CODE_W'(PER_MIN_CODE))
          per_code <= per_wr;
      end
      if (wr_en && hit_gate) begin
        gate_off[IDX_UART] <= wdata[UART_BIT];
        gate_off[IDX_I2C0] <= wdata[I2C0_BIT];
        gate_off[IDX_I2C1] <= wdata[I2C1_BIT];
      end
      if (rd_en)
        rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/clkdiv_ratio.sv
module clkdiv_ratio #(
  parameter int CODE_W   = 3,
  parameter int RST_CODE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_req,
  output logic              tick
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0]  cnt, lim;
  logic [CODE_W-1:0] code_act;
  logic              wrap;

  assign lim  = {CNT_W{1'b1}} >> (CNT_W - int'(code_act));
  assign wrap = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      code_act <= CODE_W'(RST_CODE);
      tick     <= 1'b0;
    end else begin
      tick <= wrap;
      if (wrap) begin
        cnt      <= '0;
        code_act <= code_req;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic       clk,
  input  logic       rst,
  input  logic       src_en,
  input  logic       gate_off,
  input  logic [1:0] pwr_mode,
  output logic       en_out
);
  always_ff @(posedge clk) begin
    if (rst) en_out <= 1'b0;
    else     en_out <= src_en && !gate_off && (pwr_mode < 2'd2);
  end
endmodule

// File: rtl/clkdiv_gate_ctrl.sv
module clkdiv_gate_ctrl
  import clkdiv_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int CODE_W   = 3,
  parameter bit SEC_HALF = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  input  logic [1:0]        pwr_mode,
  output logic              sys_en,
  output logic              per_en,
  output logic              sec_en,
  output logic              uart_en,
  output logic              i2c0_en,
  output logic              i2c1_en
);
  logic [CODE_W-1:0] sys_code, per_code;
  logic [NPER-1:0]   gate_off, src, gated;

  clkdiv_regs #(.ADDR_W(ADDR_W), .CODE_W(CODE_W), .SEC_HALF(SEC_HALF)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sys_code(sys_code), .per_code(per_code),
    .gate_off(gate_off)
  );

  clkdiv_ratio #(.CODE_W(CODE_W), .RST_CODE(0)) u_sys_div (
    .clk(clk), .rst(rst), .code_req(sys_code), .tick(sys_en)
  );

  clkdiv_ratio #(.CODE_W(CODE_W), .RST_CODE(PER_RST_CODE)) u_per_div (
    .clk(clk), .rst(rst), .code_req(per_code), .tick(per_en)
  );

  generate
    if (SEC_HALF) begin : g_sec_half
      logic phase, sec_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          phase <= 1'b0;
          sec_q <= 1'b0;
        end else begin
          if (sys_en) phase <= !phase;
          sec_q <= sys_en && phase;
        end
      end
      assign sec_en = sec_q;
    end else begin : g_sec_same
      assign sec_en = sys_en;
    end
  endgenerate

  assign src[IDX_UART] = sys_en;
  assign src[IDX_I2C0] = per_en;
  assign src[IDX_I2C1] = per_en;

  for (genvar g = 0; g < NPER; g++) begin : g_gate
    clkdiv_gate u_gate (
      .clk(clk), .rst(rst), .src_en(src[g]), .gate_off(gate_off[g]),
      .pwr_mode(pwr_mode), .en_out(gated[g])
    );
  end

  assign uart_en = gated[IDX_UART];
  assign i2c0_en = gated[IDX_I2C0];
  assign i2c1_en = gated[IDX_I2C1];
endmodule

// File: rtl/clkdiv_gate_ctrl_chk.sv
module clkdiv_gate_ctrl_chk #(
  parameter int ADDR_W   = 2,
  parameter bit SEC_HALF = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       rdata,
  input logic [1:0]        pwr_mode,
  input logic              sys_en,
  input logic              per_en,
  input logic              sec_en,
  input logic              uart_en,
  input logic              i2c0_en,
  input logic              i2c1_en
);
  assert_div_read_R1: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(0)) |=> (rdata[15:12] == 4'd0 && rdata[11] == SEC_HALF &&
                                       rdata[7:3] == 5'd0 && rdata[10:8] >= 3'd2 &&
                                       rdata[2:0] <= 3'd7));

  assert_gate_read_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(1)) |=> (rdata[6] && rdata[15:7] == 9'd0 && rdata[2:0] == 3'd0));

  assert_per_single_R4: assert property (@(posedge clk) disable iff (rst)
    per_en |=> !per_en);

  assert_uart_src_R8: assert property (@(posedge clk) disable iff (rst)
    uart_en |-> $past(sys_en));

  assert_i2c_src_R8: assert property (@(posedge clk) disable iff (rst)
    (i2c0_en || i2c1_en) |-> $past(per_en));

  assert_deep_off_R9: assert property (@(posedge clk) disable iff (rst)
    (pwr_mode >= 2'd2) |=> !(uart_en || i2c0_en || i2c1_en));

  generate
    if (!SEC_HALF) begin : g_sec_chk
      assert_sec_follow_R10: assert property (@(posedge clk) disable iff (rst)
        sec_en == sys_en);
    end
  endgenerate
endmodule

bind clkdiv_gate_ctrl clkdiv_gate_ctrl_chk #(.ADDR_W(ADDR_W), .SEC_HALF(SEC_HALF)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rdata(rdata), .pwr_mode(pwr_mode),
  .sys_en(sys_en), .per_en(per_en), .sec_en(sec_en), .uart_en(uart_en),
  .i2c0_en(i2c0_en), .i2c1_en(i2c1_en)
);

// File: tb/sim_clkdiv_gate_ctrl.sv
`timescale 1ns/100ps
module sim_clkdiv_gate_ctrl;
  localparam int ADDR_W = 2;
  localparam int WIN    = 200;

  // observation selectors
  localparam int S_RDATA = 0, S_SYSGAP = 1, S_PERGAP = 2, S_MIS = 3, S_GCNT = 4,
                 S_SECMIS = 5, S_ANYEN = 6;

  typedef struct {
    string tag;
    int    sel;
    int    exp;
  } item_t;

  logic              clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0]       wdata = '0, rdata;
  logic [1:0]        pwr_mode = 2'd0;
  logic              sys_en, per_en, sec_en, uart_en, i2c0_en, i2c1_en;

  item_t q[$];
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  // tracking state owned by the bench
  int cyc = 0, last_sys = 0, last_per = 0, sys_gap = 0, per_gap = 0;
  int mis = 0, gcnt = 0, secmis = 0;
  bit win_on = 1'b0, exp_u = 1'b0, exp_i0 = 1'b0, exp_i1 = 1'b0;
  logic sys_d = 1'b0, per_d = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  clkdiv_gate_ctrl #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwr_mode(pwr_mode), .sys_en(sys_en), .per_en(per_en),
    .sec_en(sec_en), .uart_en(uart_en), .i2c0_en(i2c0_en), .i2c1_en(i2c1_en)
  );

  // tracker: pulse intervals and gated-enable window statistics
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (sys_en) begin sys_gap = cyc - last_sys; last_sys = cyc; end
      if (per_en) begin per_gap = cyc - last_per; last_per = cyc; end
      if (sec_en !== sys_en) secmis++;
      if (win_on) begin
        if (uart_en !== (sys_d && exp_u))  mis++;
        if (i2c0_en !== (per_d && exp_i0)) mis++;
        if (i2c1_en !== (per_d && exp_i1)) mis++;
        gcnt += int'(uart_en) + int'(i2c0_en) + int'(i2c1_en);
      end
    end
    sys_d = sys_en;
    per_d = per_en;
  end

  // monitor: pop and compare
  always begin
    @(negedge clk);
    #0.8;
    while (q.size() > 0) begin
      item_t it;
      int    got;
      it = q.pop_front();
      case (it.sel)
        S_RDATA:  got = int'(rdata);
        S_SYSGAP: got = sys_gap;
        S_PERGAP: got = per_gap;
        S_MIS:    got = mis;
        S_GCNT:   got = gcnt;
        S_SECMIS: got = secmis;
        default:  got = int'(sys_en) + int'(per_en) + int'(uart_en) + int'(i2c0_en) + int'(i2c1_en) + int'(sec_en);
      endcase
      n_tests++;
      if (got != it.exp) begin
        n_fail++;
        $display("FAIL %s: got 0x%0h expected 0x%0h", it.tag, got, it.exp);
      end
    end
  end

  task automatic expect_v(input string tag, input int sel, input int exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #0.4;
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    #0.4;
  endtask

  task automatic rd_check(input int a, input int exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    rd_en = 1'b0;
    #0.4;
    expect_v(tag, S_RDATA, exp);
  endtask

  task automatic window(input int exp_cnt, input string tag);
    cycles(5);
    mis = 0; gcnt = 0; win_on = 1'b1;
    cycles(WIN);
    win_on = 1'b0;
    expect_v({tag, " mismatches"}, S_MIS, 0);
    expect_v({tag, " pulse count"}, S_GCNT, exp_cnt);
  endtask

  initial begin
    cycles(3);
    expect_v("R3 enables low in reset", S_ANYEN, 0);
    cycles(1);
    rst = 1'b0;

    rd_check(0, 16'h0200, "R1 ratio reset value");
    rd_check(1, 16'h0040, "R2 gate reset value");
    rd_check(2, 0, "R1 unmapped address reads 0");
    cycles(20);
    expect_v("R3 code 0 every cycle", S_SYSGAP, 1);
    expect_v("R4 reset period 4", S_PERGAP, 4);

    wr(0, 16'h0203);
    cycles(40);
    expect_v("R3 code 3 period 8", S_SYSGAP, 8);

    wr(0, 16'h0507);
    cycles(300);
    expect_v("R3 code 7 period 128", S_SYSGAP, 128);
    expect_v("R4 code 5 period 32", S_PERGAP, 32);

    // R5: reserved peripheral code ignored, system field still written
    wr(0, 16'h0105);
    rd_check(0, 16'h0505, "R5 code 001 ignored");
    wr(0, 16'h0107);
    cycles(300);
    expect_v("R5 period kept at 32", S_PERGAP, 32);

    // R6: switch 128 -> 1 mid-period
    do @(negedge clk); while (!sys_en);
    cycles(10);
    wr(0, 16'h0500);
    do begin @(negedge clk); #0.4; end while (!sys_en);
    expect_v("R6 first gap keeps old ratio", S_SYSGAP, 128);
    cycles(1);
    expect_v("R6 new ratio after wrap", S_SYSGAP, 1);
    cycles(100);
    expect_v("R7 peripheral period unchanged", S_PERGAP, 32);

    wr(0, 16'hFFFF);
    rd_check(0, 16'h0707, "R1 reserved bits read 0");
    wr(0, 16'h0000);
    rd_check(0, 16'h0700, "R5 code 000 ignored");
    wr(1, 16'hFFFF);
    rd_check(1, 16'h0078, "R2 all-ones write");
    wr(1, 16'h0000);
    rd_check(1, 16'h0040, "R2 keep-one bit");

    wr(0, 16'h0200);
    cycles(300);
    expect_v("R4 back to period 4", S_PERGAP, 4);
    expect_v("R3 back to period 1", S_SYSGAP, 1);

    // gating windows: sys every cycle (200), each I2C every 4 (50)
    exp_u = 1; exp_i0 = 1; exp_i1 = 1;
    window(300, "R8 mode0 all on");
    wr(1, 16'h0020);
    exp_u = 0;
    window(100, "R8 uart off");
    wr(1, 16'h0000);
    pwr_mode = 2'd2; exp_u = 0; exp_i0 = 0; exp_i1 = 0;
    window(0, "R9 mode2 off");
    pwr_mode = 2'd3;
    window(0, "R9 mode3 off");
    wr(1, 16'h0018);
    pwr_mode = 2'd1; exp_u = 1;
    window(200, "R8 mode1 i2c off");

    expect_v("R10 secondary follows system", S_SECMIS, 0);
    cycles(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule